// File: doc/BRIEF.md
# Inter-Core Doorbell Message Unit

This block delivers doorbell messages between the cores of a cluster. Each core can issue a send and a clear in the same cycle, each with its own 32-bit operand. The operand carries a message kind, a broadcast flag and a processor tag. The unit turns the kind into a request for either the normal doorbell or the critical doorbell. A send sets that pending bit in every core whose processor ID equals the tag. When broadcast is set, it sets the bit in all cores, including the sender.

A clear removes the decoded doorbell kind from the issuing core's own pending state and from no other core. Guest kinds and reserved kinds are dropped without effect. Every core has a hard-interrupt request line that stays high while either of its doorbells is pending. The core count, tag width and processor ID values are parameters. Choosing which pending doorbell is served first is left to the core.

Top module: `dbell_msg_unit`

## Requirements
- R1: The kind field is operand bits 31:27. Code 0 requests the normal doorbell and code 1 requests the critical doorbell. The two kinds use separate pending bits, and both update on the clock edge that samples the operation.
- R2: Kind codes 2, 3 and 4 (the guest kinds) and every code from 5 to 31 change no pending bit, whether they arrive on a send or on a clear.
- R3: When operand bit 26 (broadcast) is 1, a valid send sets the decoded bit in every core.
- R4: When broadcast is 0, a send sets the bit in every core whose processor ID equals operand bits 13:0, and in no other core. Several cores may match one tag.
- R5: A clear removes only the decoded kind, and only from the issuing core.
- R6: If a send and a clear reach the same bit of the same core in one cycle, the bit ends up set.
- R7: The sending core is a recipient when its own ID matches the tag or when broadcast is set.
- R8: The hard-interrupt line of a core is high exactly while that core has a normal or critical doorbell pending.
- R9: While reset is low, all pending bits and interrupt lines are 0, and operations are ignored.
- R10: Without valid operations, the pending state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_vld | input | NUM_CORES | Send valid, one bit per issuing core |
| snd_opnd | input | NUM_CORES*OPND_W | Send operands, core c at bits c*OPND_W +: OPND_W |
| clr_vld | input | NUM_CORES | Clear valid, one bit per issuing core |
| clr_opnd | input | NUM_CORES*OPND_W | Clear operands, same packing as snd_opnd |
| pend_norm_o | output | NUM_CORES | Normal doorbell pending, per core |
| pend_crit_o | output | NUM_CORES | Critical doorbell pending, per core |
| hard_irq_o | output | NUM_CORES | Hard-interrupt request, per core |

## Verification
The bench gives two cores the same ID, so a design that stops at the first tag match would leave one of them unset. It gives another core the largest tag, so a truncated compare would miss that core.

It sends guest and reserved kinds with broadcast set, and it clears with those kinds. A decoder that only looks at the low kind bit would then set or clear doorbells.

It clears a bit in the same cycle that another core sets it. A design where the clear wins would lose the doorbell. Self-addressed sends and broadcasts check that the sender is not left out.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
   localparam int KIND_MSB  = 31;
   localparam int KIND_LSB  = 27;
   localparam int BCAST_POS = 26;
   localparam int KIND_W    = KIND_MSB - KIND_LSB + 1;

   typedef enum logic [KIND_W-1:0] {
      DK_NORMAL     = 5'd0,
      DK_CRITICAL   = 5'd1,
      DK_GUEST      = 5'd2,
      DK_GUEST_CRIT = 5'd3,
      DK_GUEST_MC   = 5'd4
   } dbell_kind_e;

   typedef struct packed {
      logic crit;
      logic norm;
   } dbell_req_t;

   function automatic dbell_req_t kind_to_req(input logic [KIND_W-1:0] k);
      dbell_req_t r;
      r.norm = (k == DK_NORMAL);
      r.crit = (k == DK_CRITICAL);
      return r;
   endfunction
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
   import dbell_pkg::*;
#(
   parameter int OPND_W = 32,
   parameter int TAG_W  = 14
) (
   input  logic [OPND_W-1:0] opnd,
   output dbell_req_t        req,
   output logic              bcast,
   output logic [TAG_W-1:0]  tag
);
   generate
      if (OPND_W <= KIND_MSB) begin : g_bad_opnd
         $error("dbell_decode: OPND_W too narrow for kind field");
      end
      if (TAG_W < 1 || TAG_W > BCAST_POS) begin : g_bad_tag
         $error("dbell_decode: TAG_W overlaps broadcast field");
      end
   endgenerate

   always_comb begin
      req   = kind_to_req(opnd[KIND_MSB:KIND_LSB]);
      bcast = opnd[BCAST_POS];
      tag   = opnd[TAG_W-1:0];
   end
endmodule

// File: rtl/dbell_route.sv
module dbell_route
   import dbell_pkg::*;
#(
   parameter int                         NUM_CORES = 4,
   parameter int                         TAG_W     = 14,
   parameter logic [NUM_CORES*TAG_W-1:0] CORE_IDS  = '0
) (
   input  logic       [NUM_CORES-1:0]       snd_vld,
   input  dbell_req_t [NUM_CORES-1:0]       snd_req,
   input  logic       [NUM_CORES-1:0]       snd_bcast,
   input  logic       [NUM_CORES*TAG_W-1:0] snd_tag,
   output logic       [NUM_CORES-1:0]       set_norm,
   output logic       [NUM_CORES-1:0]       set_crit
);
   genvar r;
   generate
      for (r = 0; r < NUM_CORES; r++) begin : g_rcv
         localparam logic [TAG_W-1:0] MY_ID = CORE_IDS[r*TAG_W +: TAG_W];
         logic [NUM_CORES-1:0] hit;
         always_comb begin
            for (int s = 0; s < NUM_CORES; s++) begin
               hit[s] = snd_vld[s] &
                        (snd_bcast[s] | (snd_tag[s*TAG_W +: TAG_W] == MY_ID));
            end
         end
         always_comb begin
            set_norm[r] = 1'b0;
            set_crit[r] = 1'b0;
            for (int s = 0; s < NUM_CORES; s++) begin
               set_norm[r] = set_norm[r] | (hit[s] & snd_req[s].norm);
               set_crit[r] = set_crit[r] | (hit[s] & snd_req[s].crit);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dbell_pend_bank.sv
module dbell_pend_bank #(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] set_norm,
   input  logic [NUM_CORES-1:0] set_crit,
   input  logic [NUM_CORES-1:0] clr_norm,
   input  logic [NUM_CORES-1:0] clr_crit,
   output logic [NUM_CORES-1:0] pend_norm,
   output logic [NUM_CORES-1:0] pend_crit
);
   genvar c;
   generate
      for (c = 0; c < NUM_CORES; c++) begin : g_core
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_norm[c] <= 1'b0;
               pend_crit[c] <= 1'b0;
            end else begin
               pend_norm[c] <= set_norm[c] | (pend_norm[c] & ~clr_norm[c]);
               pend_crit[c] <= set_crit[c] | (pend_crit[c] & ~clr_crit[c]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dbell_msg_unit.sv
module dbell_msg_unit
   import dbell_pkg::*;
#(
   parameter int                         NUM_CORES = 4,
   parameter int                         TAG_W     = 14,
   parameter int                         OPND_W    = 32,
   parameter logic [NUM_CORES*TAG_W-1:0] CORE_IDS  = {14'd3, 14'd2, 14'd1, 14'd0}
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CORES-1:0]        snd_vld,
   input  logic [NUM_CORES*OPND_W-1:0] snd_opnd,
   input  logic [NUM_CORES-1:0]        clr_vld,
   input  logic [NUM_CORES*OPND_W-1:0] clr_opnd,
   output logic [NUM_CORES-1:0]        pend_norm_o,
   output logic [NUM_CORES-1:0]        pend_crit_o,
   output logic [NUM_CORES-1:0]        hard_irq_o
);
   generate
      if (NUM_CORES < 1) begin : g_bad_n
         $error("dbell_msg_unit: NUM_CORES must be at least 1");
      end
   endgenerate

   dbell_req_t [NUM_CORES-1:0]       s_req;
   logic       [NUM_CORES-1:0]       s_bcast;
   logic       [NUM_CORES*TAG_W-1:0] s_tag;
   dbell_req_t [NUM_CORES-1:0]       c_req;
   logic       [NUM_CORES-1:0]       c_bcast_unused;
   logic       [NUM_CORES*TAG_W-1:0] c_tag_unused;
   logic       [NUM_CORES-1:0]       set_norm, set_crit, clr_norm, clr_crit;

   genvar c;
   generate
      for (c = 0; c < NUM_CORES; c++) begin : g_dec
         dbell_decode #(.OPND_W(OPND_W), .TAG_W(TAG_W)) u_snd_dec (
            .opnd  (snd_opnd[c*OPND_W +: OPND_W]),
            .req   (s_req[c]),
            .bcast (s_bcast[c]),
            .tag   (s_tag[c*TAG_W +: TAG_W])
         );
         dbell_decode #(.OPND_W(OPND_W), .TAG_W(TAG_W)) u_clr_dec (
            .opnd  (clr_opnd[c*OPND_W +: OPND_W]),
            .req   (c_req[c]),
            .bcast (c_bcast_unused[c]),
            .tag   (c_tag_unused[c*TAG_W +: TAG_W])
         );
         assign clr_norm[c] = clr_vld[c] & c_req[c].norm;
         assign clr_crit[c] = clr_vld[c] & c_req[c].crit;
      end
   endgenerate

   dbell_route #(.NUM_CORES(NUM_CORES), .TAG_W(TAG_W), .CORE_IDS(CORE_IDS)) u_route (
      .snd_vld   (snd_vld),
      .snd_req   (s_req),
      .snd_bcast (s_bcast),
      .snd_tag   (s_tag),
      .set_norm  (set_norm),
      .set_crit  (set_crit)
   );

   dbell_pend_bank #(.NUM_CORES(NUM_CORES)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_norm  (set_norm),
      .set_crit  (set_crit),
      .clr_norm  (clr_norm),
      .clr_crit  (clr_crit),
      .pend_norm (pend_norm_o),
      .pend_crit (pend_crit_o)
   );

   assign hard_irq_o = pend_norm_o | pend_crit_o;
endmodule

// File: rtl/dbell_msg_unit_chk.sv
module dbell_msg_unit_chk #(
   parameter int                         NUM_CORES = 4,
   parameter int                         TAG_W     = 14,
   parameter int                         OPND_W    = 32,
   parameter logic [NUM_CORES*TAG_W-1:0] CORE_IDS  = '0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_CORES-1:0]        snd_vld,
   input logic [NUM_CORES*OPND_W-1:0] snd_opnd,
   input logic [NUM_CORES-1:0]        clr_vld,
   input logic [NUM_CORES*OPND_W-1:0] clr_opnd,
   input logic [NUM_CORES-1:0]        pend_norm_o,
   input logic [NUM_CORES-1:0]        pend_crit_o,
   input logic [NUM_CORES-1:0]        hard_irq_o
);
   localparam logic [NUM_CORES-1:0] ONLY_C0 = NUM_CORES'(1);

   // R10
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_vld == '0 && clr_vld == '0) |=> ($stable(pend_norm_o) && $stable(pend_crit_o)));

   // R4
   no_set_without_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_vld == '0) |=> (((pend_norm_o & ~$past(pend_norm_o)) == '0) &&
                           ((pend_crit_o & ~$past(pend_crit_o)) == '0)));

   // R3
   bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_vld[0] && snd_opnd[31:27] == 5'd0 && snd_opnd[26]) |=> (&pend_norm_o));

   // R2
   guest_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_vld == ONLY_C0 && clr_vld == '0 && snd_opnd[31:27] >= 5'd2)
      |=> ($stable(pend_norm_o) && $stable(pend_crit_o)));

   // R8
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_vld[0] && snd_opnd[31:27] == 5'd1 && snd_opnd[26]) |=> (&hard_irq_o));

   generate
      if (NUM_CORES > 1) begin : g_multi
         // R5
         clr_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vld == ONLY_C0 && snd_vld == '0)
            |=> ($stable(pend_norm_o[NUM_CORES-1:1]) && $stable(pend_crit_o[NUM_CORES-1:1])));
      end
   endgenerate
endmodule

bind dbell_msg_unit dbell_msg_unit_chk #(
   .NUM_CORES (NUM_CORES),
   .TAG_W     (TAG_W),
   .OPND_W    (OPND_W),
   .CORE_IDS  (CORE_IDS)
) u_chk (.*);

// File: tb/test_dbell_msg_unit.sv
`timescale 1ns/1ps
module test_dbell_msg_unit;
   localparam int N  = 4;
   localparam int TW = 14;
   localparam int OW = 32;
   localparam logic [N*TW-1:0] IDS = {14'd16383, 14'd42, 14'd42, 14'd5};

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n;
   logic [N-1:0]  snd_vld, clr_vld;
   logic [N*OW-1:0] snd_opnd, clr_opnd;
   logic [N-1:0]  pend_norm_o, pend_crit_o, hard_irq_o;

   dbell_msg_unit #(.NUM_CORES(N), .TAG_W(TW), .OPND_W(OW), .CORE_IDS(IDS)) i_dbell_msg_unit (
      .clk(clk), .rst_n(rst_n), .snd_vld(snd_vld), .snd_opnd(snd_opnd),
      .clr_vld(clr_vld), .clr_opnd(clr_opnd), .pend_norm_o(pend_norm_o),
      .pend_crit_o(pend_crit_o), .hard_irq_o(hard_irq_o)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [N-1:0] m_norm = '0, m_crit = '0;

   function automatic logic [31:0] mk(input int kind, input bit bc, input int tag);
      return {kind[4:0], bc, 12'd0, tag[13:0]};
   endfunction

   function automatic int id_of(input int c);
      return int'(IDS[c*TW +: TW]);
   endfunction

   task automatic compare(input string req);
      checks++;
      if (pend_norm_o !== m_norm || pend_crit_o !== m_crit || hard_irq_o !== (m_norm | m_crit)) begin
         errors++;
         $display("FAIL %s: norm=%b crit=%b irq=%b expected norm=%b crit=%b irq=%b",
                  req, pend_norm_o, pend_crit_o, hard_irq_o, m_norm, m_crit, m_norm | m_crit);
      end
   endtask

   task automatic step(input logic [N-1:0] sv, input logic [N-1:0] cv,
                       input logic [N*OW-1:0] so, input logic [N*OW-1:0] co,
                       input string req);
      logic [N-1:0] nn, nc;
      nn = m_norm; nc = m_crit;
      for (int r = 0; r < N; r++) begin
         if (cv[r] && co[r*OW+27 +: 5] == 5'd0) nn[r] = 1'b0;
         if (cv[r] && co[r*OW+27 +: 5] == 5'd1) nc[r] = 1'b0;
      end
      for (int r = 0; r < N; r++) begin
         for (int s = 0; s < N; s++) begin
            if (sv[s] && (so[s*OW+26] || int'(so[s*OW +: 14]) == id_of(r))) begin
               if (so[s*OW+27 +: 5] == 5'd0) nn[r] = 1'b1;
               if (so[s*OW+27 +: 5] == 5'd1) nc[r] = 1'b1;
            end
         end
      end
      snd_vld = sv; clr_vld = cv; snd_opnd = so; clr_opnd = co;
      @(posedge clk);
      @(negedge clk);
      snd_vld = '0; clr_vld = '0;
      m_norm = nn; m_crit = nc;
      compare(req);
   endtask

   function automatic logic [N*OW-1:0] one(input int c, input logic [31:0] op);
      logic [N*OW-1:0] v = '0;
      v[c*OW +: OW] = op;
      return v;
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int kinds[5] = '{2, 3, 4, 17, 31};
      void'($urandom(32'd2024));
      rst_n = 1'b0;
      snd_vld = '0; clr_vld = '0; snd_opnd = '0; clr_opnd = '0;
      @(negedge clk);
      // R9: operations during reset are ignored
      snd_vld = 4'b0001; snd_opnd = one(0, mk(0, 1, 0));
      repeat (3) @(negedge clk);
      snd_vld = '0;
      compare("R9");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R9");

      // R1 R4: normal to tag 5 reaches core 0 only
      step(4'b0010, '0, one(1, mk(0, 0, 5)), '0, "R1_R4");
      // R4: critical to shared tag 42 reaches cores 1 and 2
      step(4'b1000, '0, one(3, mk(1, 0, 42)), '0, "R4");
      // R2: guest and reserved kinds with broadcast are dropped
      foreach (kinds[i]) step(4'b0001, '0, one(0, mk(kinds[i], 1, 0)), '0, "R2");
      // R3: broadcast normal
      step(4'b0100, '0, one(2, mk(0, 1, 777)), '0, "R3");
      // R5: core 1 clears critical, only its own
      step('0, 4'b0010, '0, one(1, mk(1, 0, 0)), "R5");
      // R2: clear with a guest kind changes nothing
      step('0, 4'b1111, '0, {mk(3,0,0), mk(4,0,0), mk(2,0,0), mk(31,0,0)}, "R2");
      // R6: core 2 clears normal while core 3 sends normal to tag 42
      step(4'b1000, 4'b0100, one(3, mk(0, 0, 42)), one(2, mk(0, 0, 0)), "R6");
      // R7: core 3 addresses itself with largest tag
      step(4'b1000, '0, one(3, mk(1, 0, 16383)), '0, "R7");
      // R7: broadcast critical includes sender core 1
      step(4'b0010, '0, one(1, mk(1, 1, 0)), '0, "R7");
      // R8: clear everything, interrupt lines drop
      step('0, 4'b1111, '0, {4{mk(0, 0, 0)}}, "R8");
      step('0, 4'b1111, '0, {4{mk(1, 0, 0)}}, "R8");
      // R10: idle holds
      step(4'b0001, '0, one(0, mk(1, 0, 42)), '0, "R10");
      repeat (3) step('0, '0, '0, '0, "R10");

      // Random mix covering R1 through R7
      for (int it = 0; it < 600; it++) begin
         logic [N*OW-1:0] so, co;
         for (int c = 0; c < N; c++) begin
            int sel, k, t;
            sel = $urandom % 8;
            k = (sel < 3) ? 0 : (sel < 6) ? 1 : (sel == 6) ? 2 + $urandom % 3 : $urandom % 32;
            t = ($urandom % 10 < 7) ? id_of($urandom % N) : $urandom % 16384;
            so[c*OW +: OW] = mk(k, ($urandom % 5) == 0, t);
            sel = $urandom % 8;
            k = (sel < 4) ? 0 : (sel < 7) ? 1 : $urandom % 32;
            co[c*OW +: OW] = mk(k, $urandom % 2, $urandom % 16384);
         end
         step(N'($urandom), N'($urandom & $urandom), so, co, "R1_R3_R4_R5_R6");
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule